// File: doc/BRIEF.md
# Next-Free-Entry Priority Locator

This block tracks whether each entry of a lookup array is occupied and keeps the index of the free entry with the highest priority. That index is where the next write-to-free-entry cycle will place its data. Index 0 has the highest priority. Occupancy changes arrive on a single set/clear port. The search is a combinational priority encoder whose result is registered once.

When a read-next-free command arrives, the block places a 32-bit word on its bus output. The word carries the entry index in its low bits and the device's 4-bit page number in bits 19:16. The block answers only when it is the active device of a vertical cascade. That means the full-in of the device above it is asserted (low) and the block itself is not full. An active-low full flag and an active-low full-out extend the cascade to the next device.

A small responder decides whether this device answers a status read. After a compare, the answer comes from the highest-priority device that matched. If no device matched, the last device in the chain answers. After a random memory access, every selected device answers.

Top module: `nfa_locator`

## Requirements
- R1: After reset every entry is free, `fullFlagN` is high, `busDrive`, `busOut` and `statusDrive` are low, and the first read-next-free reports index 0.
- R2: `validSet` marks entry `validIdx` occupied and `validClr` marks it free, at the next edge. When both are high in one cycle, the entry becomes occupied.
- R3: A read-next-free reports the lowest-numbered free entry. The result appears on `busDrive`/`busOut` one cycle after the command. It reflects every occupancy change made two or more cycles before the command.
- R4: The driven word holds the index in bits [ADDR_W-1:0] and `pageAddr` in bits 19:16. All other bits are zero. While `busDrive` is low, `busOut` is all zero.
- R5: A read-next-free is answered only when `fullInN` is low and `fullFlagN` is high. Otherwise `busDrive` stays low.
- R6: `fullFlagN` goes low once every entry is occupied, two cycles after the last set. `fullOutN` is low exactly when `fullFlagN` is low and `fullInN` is low.
- R7: After a compare with a local hit, a status read is answered when `matchIn` is low. It is never answered while `matchIn` is high.
- R8: After a compare without a local hit, a status read with `matchIn` low is answered only by a device whose `isLast` is high.
- R9: After a random access (`memAccess`), a status read is answered exactly when `devSelected` is high.
- R10: If `cmpStrobe` and `memAccess` are high in the same cycle, the compare rule governs later status reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validSet | input | 1 | Mark entry `validIdx` occupied |
| validClr | input | 1 | Mark entry `validIdx` free |
| validIdx | input | ADDR_W | Entry addressed by set/clear |
| pageAddr | input | 4 | Page number of this device |
| fullInN | input | 1 | Low when all higher devices are full |
| rdNextFree | input | 1 | Read-next-free command |
| busOut | output | 32 | Response word |
| busDrive | output | 1 | Response word valid |
| fullFlagN | output | 1 | Low when no entry is free |
| fullOutN | output | 1 | Full-in for the next device |
| cmpStrobe | input | 1 | A compare took place |
| cmpHit | input | 1 | Local match result of that compare |
| memAccess | input | 1 | A random memory access took place |
| matchIn | input | 1 | A higher-priority device matched |
| isLast | input | 1 | Strap: lowest-priority device of the chain |
| devSelected | input | 1 | This device is selected |
| statusRead | input | 1 | Status read command |
| statusDrive | output | 1 | This device answers the status read |

## Verification
An occupancy change takes effect at the edge after it is driven, and the registered encoder follows one edge later. The bench therefore leaves one idle cycle after every set or clear before it issues a read. Both read responses (`busDrive`/`busOut` and `statusDrive`) are registered. The bench drives each command on a falling edge and samples its response on the next falling edge, exactly one rising edge later. `fullOutN` is combinational from `fullInN`, so the bench checks it on the falling edge at which it changes `fullInN`.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  localparam int PAGE_W   = 4;
  localparam int PAGE_LSB = 16;
  localparam int BUS_W    = 32;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic nfaDrive;
  } strobe_t;
endpackage

// File: rtl/nfa_ctrl.sv
module nfa_ctrl (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validSet,
  input  logic              validClr,
  input  logic              rdNextFree,
  input  logic              fullInN,
  input  logic              nfAny,
  input  logic              cmpStrobe,
  input  logic              cmpHit,
  input  logic              memAccess,
  input  logic              matchIn,
  input  logic              isLast,
  input  logic              devSelected,
  input  logic              statusRead,
  output nfa_pkg::strobe_t  strobes,
  output logic              statusDrive
);
  logic cmpModeQ;
  logic hitQ;
  logic respond;

  always_comb begin
    strobes.setEn    = validSet;
    strobes.clrEn    = validClr & ~validSet;
    strobes.nfaDrive = rdNextFree & ~fullInN & nfAny;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpModeQ <= 1'b0;
      hitQ     <= 1'b0;
    end else if (cmpStrobe) begin
      cmpModeQ <= 1'b1;
      hitQ     <= cmpHit;
    end else if (memAccess) begin
      cmpModeQ <= 1'b0;
      hitQ     <= 1'b0;
    end
  end

  always_comb begin
    if (cmpModeQ) respond = ~matchIn & (hitQ | isLast);
    else          respond = devSelected;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusDrive <= 1'b0;
    else       statusDrive <= statusRead & respond;
  end

  AST_MATCHIN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && matchIn && cmpModeQ) |=> !statusDrive); // R7
  AST_ACCESS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !cmpModeQ) |=> (statusDrive == $past(devSelected))); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.setEn && strobes.clrEn)); // R2
endmodule

// File: rtl/nfa_datapath.sv
module nfa_datapath #(
  parameter int ENTRIES = 64,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  nfa_pkg::strobe_t                  strobes,
  input  logic [ADDR_W-1:0]                 validIdx,
  input  logic [nfa_pkg::PAGE_W-1:0]        pageAddr,
  input  logic                              fullInN,
  output logic                              nfAny,
  output logic [nfa_pkg::BUS_W-1:0]         busOut,
  output logic                              busDrive,
  output logic                              fullFlagN,
  output logic                              fullOutN
);
  logic [ENTRIES-1:0] occQ;
  logic [ADDR_W-1:0]  encIdx;
  logic               encAny;
  logic [ADDR_W-1:0]  nfIdxQ;
  logic               nfAnyQ;
  logic [nfa_pkg::BUS_W-1:0] word;

  always_ff @(posedge clk) begin
    if (!rstN)                occQ <= '0;
    else if (strobes.setEn)   occQ[validIdx] <= 1'b1;
    else if (strobes.clrEn)   occQ[validIdx] <= 1'b0;
  end

  always_comb begin
    encIdx = '0;
    encAny = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!occQ[i]) begin
        encIdx = ADDR_W'(i);
        encAny = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nfIdxQ <= '0;
      nfAnyQ <= 1'b1;
    end else begin
      nfIdxQ <= encIdx;
      nfAnyQ <= encAny;
    end
  end

  always_comb begin
    word = '0;
    word[ADDR_W-1:0] = nfIdxQ;
    word[nfa_pkg::PAGE_LSB +: nfa_pkg::PAGE_W] = pageAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busOut   <= '0;
      busDrive <= 1'b0;
    end else begin
      busOut   <= strobes.nfaDrive ? word : '0;
      busDrive <= strobes.nfaDrive;
    end
  end

  assign nfAny     = nfAnyQ;
  assign fullFlagN = nfAnyQ;
  assign fullOutN  = nfAnyQ | fullInN;

  AST_SET_MARKS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setEn |=> occQ[$past(validIdx)]); // R2
  AST_CLR_FREES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrEn |=> !occQ[$past(validIdx)]); // R2
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busOut[nfa_pkg::BUS_W-1:20] == '0); // R4
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !busDrive |-> (busOut == '0)); // R4
  AST_DRIVE_NOT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> $past(nfAnyQ)); // R5
  AST_FULLOUT_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !fullOutN |-> (!fullFlagN && !fullInN)); // R6
endmodule

// File: rtl/nfa_locator.sv
module nfa_locator #(
  parameter int ENTRIES = 64,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validSet,
  input  logic              validClr,
  input  logic [ADDR_W-1:0] validIdx,
  input  logic [3:0]        pageAddr,
  input  logic              fullInN,
  input  logic              rdNextFree,
  output logic [31:0]       busOut,
  output logic              busDrive,
  output logic              fullFlagN,
  output logic              fullOutN,
  input  logic              cmpStrobe,
  input  logic              cmpHit,
  input  logic              memAccess,
  input  logic              matchIn,
  input  logic              isLast,
  input  logic              devSelected,
  input  logic              statusRead,
  output logic              statusDrive
);
  nfa_pkg::strobe_t strobes;
  logic             nfAny;

  nfa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .validSet(validSet), .validClr(validClr),
    .rdNextFree(rdNextFree), .fullInN(fullInN), .nfAny(nfAny),
    .cmpStrobe(cmpStrobe), .cmpHit(cmpHit), .memAccess(memAccess),
    .matchIn(matchIn), .isLast(isLast), .devSelected(devSelected),
    .statusRead(statusRead),
    .strobes(strobes), .statusDrive(statusDrive)
  );

  nfa_datapath #(.ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .validIdx(validIdx), .pageAddr(pageAddr),
    .fullInN(fullInN), .nfAny(nfAny),
    .busOut(busOut), .busDrive(busDrive),
    .fullFlagN(fullFlagN), .fullOutN(fullOutN)
  );
endmodule

// File: tb/nfa_locator_tb.sv
`timescale 1ns/1ps
module nfa_locator_tb;
  localparam int ENTRIES = 64;
  localparam int ADDR_W  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validSet = 0, validClr = 0;
  logic [ADDR_W-1:0] validIdx = '0;
  logic [3:0] pageAddr = 4'h0;
  logic fullInN = 1'b0, rdNextFree = 1'b0;
  logic [31:0] busOut;
  logic busDrive, fullFlagN, fullOutN;
  logic cmpStrobe = 0, cmpHit = 0, memAccess = 0, matchIn = 0, isLast = 0;
  logic devSelected = 0, statusRead = 0;
  logic statusDrive;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nfa_locator #(.ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rstN(rstN), .validSet(validSet), .validClr(validClr),
    .validIdx(validIdx), .pageAddr(pageAddr), .fullInN(fullInN),
    .rdNextFree(rdNextFree), .busOut(busOut), .busDrive(busDrive),
    .fullFlagN(fullFlagN), .fullOutN(fullOutN), .cmpStrobe(cmpStrobe),
    .cmpHit(cmpHit), .memAccess(memAccess), .matchIn(matchIn),
    .isLast(isLast), .devSelected(devSelected), .statusRead(statusRead),
    .statusDrive(statusDrive)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] word(logic [3:0] pg, int idx);
    return (32'(pg) << 16) | 32'(idx);
  endfunction

  task automatic setEntry(int idx);
    validIdx = ADDR_W'(idx); validSet = 1; tick(); validSet = 0;
  endtask

  task automatic clrEntry(int idx);
    validIdx = ADDR_W'(idx); validClr = 1; tick(); validClr = 0;
  endtask

  task automatic readNf(string req, logic expDrive, logic [31:0] expWord);
    tick();
    rdNextFree = 1; tick(); rdNextFree = 0;
    check(req, {31'b0, busDrive}, {31'b0, expDrive});
    check(req, busOut, expWord);
    tick();
    check({req, " idle bus"}, busOut, 32'h0);
  endtask

  task automatic doStatus(string req, logic expResp);
    statusRead = 1; tick(); statusRead = 0;
    check(req, {31'b0, statusDrive}, {31'b0, expResp});
  endtask

  task automatic doCompare(logic hit);
    cmpStrobe = 1; cmpHit = hit; tick(); cmpStrobe = 0; cmpHit = 0;
  endtask

  task automatic testReset();
    check("R1 fullFlagN", {31'b0, fullFlagN}, 32'h1);
    check("R1 busDrive", {31'b0, busDrive}, 32'h0);
    check("R1 busOut", busOut, 32'h0);
    check("R1 statusDrive", {31'b0, statusDrive}, 32'h0);
    readNf("R1 first free", 1'b1, word(4'h0, 0));
  endtask

  task automatic testPriority();
    setEntry(0); setEntry(1); setEntry(2);
    readNf("R3 after 0..2 set", 1'b1, word(4'h0, 3));
    clrEntry(1);
    readNf("R3 after clear 1", 1'b1, word(4'h0, 1));
    setEntry(1);
    readNf("R2 set again", 1'b1, word(4'h0, 3));
    validIdx = ADDR_W'(3); validSet = 1; validClr = 1; tick();
    validSet = 0; validClr = 0;
    readNf("R2 set wins over clear", 1'b1, word(4'h0, 4));
  endtask

  task automatic testFormat();
    pageAddr = 4'hA;
    readNf("R4 page and index", 1'b1, word(4'hA, 4));
    pageAddr = 4'h5;
    setEntry(4);
    readNf("R4 page 5 index 5", 1'b1, word(4'h5, 5));
  endtask

  task automatic testGate();
    fullInN = 1;
    readNf("R5 fullInN high", 1'b0, 32'h0);
    fullInN = 0;
  endtask

  task automatic testFull();
    for (int i = 5; i < ENTRIES; i++) setEntry(i);
    tick();
    check("R6 fullFlagN low", {31'b0, fullFlagN}, 32'h0);
    check("R6 fullOutN low", {31'b0, fullOutN}, 32'h0);
    fullInN = 1; #0.1;
    check("R6 fullOutN follows fullInN", {31'b0, fullOutN}, 32'h1);
    fullInN = 0;
    readNf("R5 full device silent", 1'b0, 32'h0);
    clrEntry(ENTRIES - 1);
    tick();
    check("R6 fullFlagN high again", {31'b0, fullFlagN}, 32'h1);
    check("R6 fullOutN high", {31'b0, fullOutN}, 32'h1);
    readNf("R3 only last free", 1'b1, word(4'h5, ENTRIES - 1));
  endtask

  task automatic testResponder();
    devSelected = 1; doStatus("R9 access selected", 1'b1);
    devSelected = 0; doStatus("R9 access not selected", 1'b0);
    doCompare(1'b1);
    matchIn = 0; doStatus("R7 hit no matchIn", 1'b1);
    matchIn = 1; doStatus("R7 hit with matchIn", 1'b0);
    matchIn = 0;
    doCompare(1'b0);
    isLast = 0; doStatus("R8 miss not last", 1'b0);
    isLast = 1; doStatus("R8 miss last", 1'b1);
    matchIn = 1; doStatus("R8 miss last matchIn", 1'b0);
    matchIn = 0; isLast = 0;
    memAccess = 1; tick(); memAccess = 0;
    devSelected = 1; doStatus("R9 back to access", 1'b1);
    devSelected = 0;
    cmpStrobe = 1; cmpHit = 1; memAccess = 1; tick();
    cmpStrobe = 0; cmpHit = 0; memAccess = 0;
    doStatus("R10 compare wins", 1'b1);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    testReset();
    testPriority();
    testFormat();
    testGate();
    testFull();
    testResponder();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule